// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between an SDRAM command scheduler and the memory command bus. The scheduler raises a request for a REFRESH, an ACTIVATE, a PRECHARGE or a READ/WRITE, along with one bank index that applies to every request in that cycle. The block grants a request only when all of that command's minimum spacings have elapsed. A grant is combinational in the requesting cycle, so the scheduler can put the command on the bus in that same cycle. At most one command is granted per cycle.

The spacings come from a 32-bit timing word. A load strobe latches that word, and the new spacings govern every command granted from the next cycle on. Each limit is counted by its own down-counter. The ACTIVATE-related counters and the PRECHARGE counter are kept separately for each internal bank, while the REFRESH counter and the ACTIVATE-to-ACTIVATE counter are global.

Read latency is shadowed. It changes only when the program-enable input rises. A one-cycle read-data-valid strobe marks the first data beat of every granted READ, and reads may be pipelined on consecutive cycles. When a field holds a reserved code, the block uses the longest legal spacing for that field and raises a sticky error flag.

Top module: `sdram_cmd_timer`

## Requirements
- R1: After reset, the active timing word is 0x2A733225. This gives read latency 2, REFRESH spacing 11, ACTIVATE-to-PRECHARGE 8, PRECHARGE-to-ACTIVATE 3, ACTIVATE-to-READ/WRITE 3 and ACTIVATE-to-ACTIVATE 2 clocks. All grants are 0 when nothing is requested, and `rdValid` and `cfgErr` are 0.
- R2: After a REFRESH granted in cycle t, neither REFRESH nor ACTIVATE (any bank) is granted before cycle t+N. N is bits 27:24 plus 1 (range 2..16).
- R3: After an ACTIVATE to bank b in cycle t, PRECHARGE to bank b is not granted before t+N. N is bits 23:20 plus 1.
- R4: After a PRECHARGE to bank b in cycle t, ACTIVATE to bank b is not granted before t+N. N is the value of bits 18:16 (1..7).
- R5: After an ACTIVATE to bank b in cycle t, READ/WRITE to bank b is not granted before t+N. N is the value of bits 14:12 (1..7).
- R6: An ACTIVATE to a bank other than the last activated one needs two things. First, at least N clocks must have passed since that ACTIVATE, where N is the value of bits 10:8 (1..7). Second, a READ/WRITE must have been granted after it.
- R7: At most one grant per cycle, and only for a raised request. Among the requests whose spacings are met, the priority order is REFRESH, PRECHARGE, ACTIVATE, READ/WRITE.
- R8: A READ granted in cycle t (`reqRw` with `rwRead`=1) gives `rdValid`=1 in exact cycle t+L, where L is the active latency. This holds for READs on consecutive cycles. WRITEs (`rwRead`=0) give no pulse.
- R9: Latency is bits 30:28 (codes 2..7 = that many clocks). A newly loaded latency takes effect only in the cycle after `progEn` goes from 0 to 1. It applies to READs granted from that cycle on.
- R10: Certain codes are reserved: latency 000/001, REFRESH or ACTIVATE-to-PRECHARGE 0000, and any 3-bit spacing 000. A reserved code acts as 7 clocks for the latency and 3-bit fields and 16 for the 4-bit fields. Loading a word with any reserved code sets `cfgErr`, which stays 1 until reset. Bits 31, 19, 15 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Timing word to latch |
| cfgLoad | input | 1 | Latch `cfgWord` at this edge |
| progEn | input | 1 | Rising edge applies the latched latency |
| reqRef | input | 1 | REFRESH request |
| reqAct | input | 1 | ACTIVATE request |
| reqPre | input | 1 | PRECHARGE request |
| reqRw | input | 1 | READ/WRITE request |
| rwRead | input | 1 | 1 = READ, 0 = WRITE for `reqRw` |
| bankSel | input | 2 | Internal bank of the request |
| gntRef | output | 1 | REFRESH granted this cycle |
| gntAct | output | 1 | ACTIVATE granted this cycle |
| gntPre | output | 1 | PRECHARGE granted this cycle |
| gntRw | output | 1 | READ/WRITE granted this cycle |
| rdValid | output | 1 | First read data beat valid |
| cfgErr | output | 1 | Sticky reserved-code flag |

## Verification
Two functions can fall in the same cycle: a new READ grant, and the data-valid strobe of an earlier READ. The bench provokes this with a run of READs to one open bank on consecutive cycles, and again with random READ traffic. In every cycle it compares the grant against a timestamp model of the spacing rules. It also compares `rdValid` against a schedule of due cycles that the model fills in at each expected READ grant, so a pipeline that drops, merges or shifts strobes under overlap shows up as a miscompare.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int CNT_W     = 4;
  localparam int LAT_W     = 3;
  localparam int MAX_LAT   = 7;

  // layout of the 32-bit timing word; field positions are fixed by software
  typedef struct packed {
    logic       spare31;
    logic [2:0] latCode;
    logic [3:0] refGapCode;
    logic [3:0] actPreCode;
    logic       spare19;
    logic [2:0] preActCode;
    logic       spare15;
    logic [2:0] actRwCode;
    logic       spare11;
    logic [2:0] actActCode;
    logic [7:0] spareLow;
  } timing_word_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              issueRef;
    logic              issueAct;
    logic              issuePre;
    logic              issueRw;
    logic              issueRead;
    logic [BANK_W-1:0] bank;
    logic              loadCfg;
    logic              applyLat;
  } strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic                 refIdle;
    logic                 actActIdle;
    logic                 actNoRw;
    logic [BANK_W-1:0]    lastActBank;
    logic [NUM_BANKS-1:0] actPreIdle;
    logic [NUM_BANKS-1:0] preActIdle;
    logic [NUM_BANKS-1:0] actRwIdle;
  } status_t;

  // reload = spacing - 1; 4-bit fields encode spacing-1 directly, 0 -> 16 clocks
  function automatic logic [CNT_W-1:0] wideReload(input logic [3:0] code);
    return (code == 4'd0) ? CNT_W'(15) : CNT_W'(code);
  endfunction

  // 3-bit fields encode the spacing itself, 0 -> 7 clocks
  function automatic logic [CNT_W-1:0] narrowReload(input logic [2:0] code);
    return (code == 3'd0) ? CNT_W'(6) : CNT_W'(code - 3'd1);
  endfunction

  function automatic logic [LAT_W-1:0] latDecode(input logic [2:0] code);
    return (code < 3'd2) ? LAT_W'(MAX_LAT) : LAT_W'(code);
  endfunction

  function automatic logic hasReserved(input timing_word_t w);
    return (w.latCode < 3'd2) || (w.refGapCode == 4'd0) || (w.actPreCode == 4'd0) ||
           (w.preActCode == 3'd0) || (w.actRwCode == 3'd0) || (w.actActCode == 3'd0);
  endfunction
endpackage

// File: rtl/sct_spacing_ctr.sv
module sct_spacing_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         idle
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (load)           cnt <= loadVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign idle = (cnt == '0);

  // a counter left alone never leaves zero (spacing completes, no wrap) - R2
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (idle && !load) |=> idle);
endmodule

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_pkg::*;
#(
  parameter logic [31:0] RESET_CFG = 32'h2A73_3225
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [31:0]  cfgIn,
  output status_t      stat,
  output logic         rdValid,
  output logic         cfgErr
);
  timing_word_t      cfgReg;
  timing_word_t      cfgNew;
  logic [LAT_W-1:0]  activeLat;
  logic [MAX_LAT-1:0] rdPipe;
  logic [LAT_W-1:0]  tapIdx;
  logic              actNoRwQ;
  logic [BANK_W-1:0] lastActBankQ;

  logic [CNT_W-1:0] refReload, actPreReload, preActReload, actRwReload, actActReload;

  assign cfgNew = timing_word_t'(cfgIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= timing_word_t'(RESET_CFG);
      activeLat <= latDecode(RESET_CFG[30:28]);
      cfgErr    <= 1'b0;
    end else begin
      // latency copy uses the word latched before this edge
      if (strb.applyLat) activeLat <= latDecode(cfgReg.latCode);
      if (strb.loadCfg) begin
        cfgReg <= cfgNew;
        if (hasReserved(cfgNew)) cfgErr <= 1'b1;
      end
    end
  end

  assign refReload    = wideReload(cfgReg.refGapCode);
  assign actPreReload = wideReload(cfgReg.actPreCode);
  assign preActReload = narrowReload(cfgReg.preActCode);
  assign actRwReload  = narrowReload(cfgReg.actRwCode);
  assign actActReload = narrowReload(cfgReg.actActCode);

  sct_spacing_ctr #(.W(CNT_W)) refCtr_i (
    .clk(clk), .rstN(rstN), .load(strb.issueRef), .loadVal(refReload), .idle(stat.refIdle));

  sct_spacing_ctr #(.W(CNT_W)) actActCtr_i (
    .clk(clk), .rstN(rstN), .load(strb.issueAct), .loadVal(actActReload), .idle(stat.actActIdle));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hitBank;
    assign hitBank = (strb.bank == BANK_W'(b));

    sct_spacing_ctr #(.W(CNT_W)) actPreCtr_i (
      .clk(clk), .rstN(rstN), .load(strb.issueAct && hitBank),
      .loadVal(actPreReload), .idle(stat.actPreIdle[b]));

    sct_spacing_ctr #(.W(CNT_W)) preActCtr_i (
      .clk(clk), .rstN(rstN), .load(strb.issuePre && hitBank),
      .loadVal(preActReload), .idle(stat.preActIdle[b]));

    sct_spacing_ctr #(.W(CNT_W)) actRwCtr_i (
      .clk(clk), .rstN(rstN), .load(strb.issueAct && hitBank),
      .loadVal(actRwReload), .idle(stat.actRwIdle[b]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actNoRwQ     <= 1'b0;
      lastActBankQ <= '0;
    end else if (strb.issueAct) begin
      actNoRwQ     <= 1'b1;
      lastActBankQ <= strb.bank;
    end else if (strb.issueRw) begin
      actNoRwQ     <= 1'b0;
    end
  end

  assign stat.actNoRw     = actNoRwQ;
  assign stat.lastActBank = lastActBankQ;

  // read-valid delay line, tapped at the active latency
  always_ff @(posedge clk) begin
    if (!rstN) rdPipe <= '0;
    else       rdPipe <= {rdPipe[MAX_LAT-2:0], strb.issueRead};
  end

  assign tapIdx  = activeLat - LAT_W'(1);
  assign rdValid = rdPipe[tapIdx];

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |=> cfgErr);

  assert_lat_shadow_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyLat |=> $stable(activeLat));

  assert_lat_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    activeLat >= LAT_W'(2));
endmodule

// File: rtl/sct_control.sv
module sct_control
  import sct_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic              progEn,
  input  logic              reqRef,
  input  logic              reqAct,
  input  logic              reqPre,
  input  logic              reqRw,
  input  logic              rwRead,
  input  logic [BANK_W-1:0] bankSel,
  input  status_t           stat,
  output logic              gntRef,
  output logic              gntAct,
  output logic              gntPre,
  output logic              gntRw,
  output strobe_t           strb
);
  logic progQ;
  logic refOk, actOk, preOk, rwOk, otherBank;

  always_ff @(posedge clk) begin
    if (!rstN) progQ <= 1'b0;
    else       progQ <= progEn;
  end

  always_comb begin
    otherBank = (bankSel != stat.lastActBank);
    refOk = stat.refIdle;
    preOk = stat.actPreIdle[bankSel];
    actOk = stat.refIdle && stat.preActIdle[bankSel] &&
            (!otherBank || (stat.actActIdle && !stat.actNoRw));
    rwOk  = stat.actRwIdle[bankSel];

    gntRef = reqRef && refOk;
    gntPre = !gntRef && reqPre && preOk;
    gntAct = !gntRef && !gntPre && reqAct && actOk;
    gntRw  = !gntRef && !gntPre && !gntAct && reqRw && rwOk;
  end

  always_comb begin
    strb.issueRef  = gntRef;
    strb.issueAct  = gntAct;
    strb.issuePre  = gntPre;
    strb.issueRw   = gntRw;
    strb.issueRead = gntRw && rwRead;
    strb.bank      = bankSel;
    strb.loadCfg   = cfgLoad;
    strb.applyLat  = progEn && !progQ;
  end

  assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gntRef, gntAct, gntPre, gntRw}));

  assert_grant_has_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gntRef |-> reqRef) and (gntAct |-> reqAct) and (gntPre |-> reqPre) and (gntRw |-> reqRw));

  assert_ref_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    gntRef |=> !(gntRef || gntAct));

  assert_act_pre_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    gntAct |=> !(gntPre && bankSel == $past(bankSel)));

  assert_no_act_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    gntAct |=> !(gntAct && bankSel != $past(bankSel)));
endmodule

// File: rtl/sdram_cmd_timer.sv
module sdram_cmd_timer
  import sct_pkg::*;
#(
  parameter logic [31:0] RESET_CFG = 32'h2A73_3225
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       cfgWord,
  input  logic              cfgLoad,
  input  logic              progEn,
  input  logic              reqRef,
  input  logic              reqAct,
  input  logic              reqPre,
  input  logic              reqRw,
  input  logic              rwRead,
  input  logic [BANK_W-1:0] bankSel,
  output logic              gntRef,
  output logic              gntAct,
  output logic              gntPre,
  output logic              gntRw,
  output logic              rdValid,
  output logic              cfgErr
);
  strobe_t strb;
  status_t stat;

  sct_control ctrl_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .progEn(progEn),
    .reqRef(reqRef), .reqAct(reqAct), .reqPre(reqPre), .reqRw(reqRw),
    .rwRead(rwRead), .bankSel(bankSel), .stat(stat),
    .gntRef(gntRef), .gntAct(gntAct), .gntPre(gntPre), .gntRw(gntRw), .strb(strb));

  sct_datapath #(.RESET_CFG(RESET_CFG)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgIn(cfgWord),
    .stat(stat), .rdValid(rdValid), .cfgErr(cfgErr));
endmodule

// File: tb/sdram_cmd_timer_tb_top.sv
module sdram_cmd_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        cfgLoad = 1'b0, progEn = 1'b0;
  logic        reqRef = 0, reqAct = 0, reqPre = 0, reqRw = 0, rwRead = 0;
  logic [1:0]  bankSel = '0;
  logic        gntRef, gntAct, gntPre, gntRw, rdValid, cfgErr;

  always #2 clk = ~clk;  // 250 MHz

  sdram_cmd_timer dut_i (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .cfgLoad(cfgLoad), .progEn(progEn),
    .reqRef(reqRef), .reqAct(reqAct), .reqPre(reqPre), .reqRw(reqRw), .rwRead(rwRead),
    .bankSel(bankSel), .gntRef(gntRef), .gntAct(gntAct), .gntPre(gntPre), .gntRw(gntRw),
    .rdValid(rdValid), .cfgErr(cfgErr));

  int vectors = 0, fails = 0;
  bit finished = 0;

  // reference model: timestamps of last commands and decoded spacings
  int cyc = 0;
  int mLastRef = -1000, mLastActT = -1000, mLastActB = 0;
  int mLastAct[4], mLastPre[4];
  bit mNoRw = 0, mErr = 0, mProgPrev = 0;
  bit mDue[64];
  logic [31:0] mReg = 32'h2A73_3225;
  int mLat = 2;
  logic [31:0] nextWord = '0;
  bit doLoad = 0, doProg = 0;

  function automatic int gap4(input logic [3:0] c);  return (c == 0) ? 16 : int'(c) + 1; endfunction
  function automatic int gap3(input logic [2:0] c);  return (c == 0) ? 7 : int'(c); endfunction
  function automatic int latOf(input logic [2:0] c); return (c < 2) ? 7 : int'(c); endfunction
  function automatic bit badWord(input logic [31:0] w);
    return (w[30:28] < 2) || (w[27:24] == 0) || (w[23:20] == 0) ||
           (w[18:16] == 0) || (w[14:12] == 0) || (w[10:8] == 0);
  endfunction

  task automatic cmp(input bit act, input bit exp, input string what, input string req);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit r, input bit a, input bit p, input bit w, input bit rd,
                      input int b, input string tag);
    bit eRef, eAct, ePre, eRw, eRd, actOk;
    int tRc, tRas, tRp, tRcd, tRrd;
    @(negedge clk);
    reqRef = r; reqAct = a; reqPre = p; reqRw = w; rwRead = rd; bankSel = 2'(b);
    cfgLoad = doLoad; cfgWord = nextWord; progEn = doProg;
    #1;
    tRc = gap4(mReg[27:24]); tRas = gap4(mReg[23:20]);
    tRp = gap3(mReg[18:16]); tRcd = gap3(mReg[14:12]); tRrd = gap3(mReg[10:8]);
    actOk = (cyc - mLastRef >= tRc) && (cyc - mLastPre[b] >= tRp) &&
            (b == mLastActB || (!mNoRw && cyc - mLastActT >= tRrd));
    eRef = r && (cyc - mLastRef >= tRc);
    ePre = !eRef && p && (cyc - mLastAct[b] >= tRas);
    eAct = !eRef && !ePre && a && actOk;
    eRw  = !eRef && !ePre && !eAct && w && (cyc - mLastAct[b] >= tRcd);
    eRd  = mDue[cyc % 64];
    vectors++;
    cmp(gntRef, eRef, "gntRef", (tag != "") ? tag : "R2");
    cmp(gntPre, ePre, "gntPre", (tag != "") ? tag : "R3");
    cmp(gntAct, eAct, "gntAct", (tag != "") ? tag : "R4/R6");
    cmp(gntRw,  eRw,  "gntRw",  (tag != "") ? tag : "R5");
    cmp(rdValid, eRd, "rdValid", (tag != "") ? tag : "R8");
    cmp(cfgErr, mErr, "cfgErr", (tag != "") ? tag : "R10");
    @(posedge clk);
    mDue[cyc % 64] = 0;
    if (eRef) mLastRef = cyc;
    if (ePre) mLastPre[b] = cyc;
    if (eAct) begin mLastAct[b] = cyc; mLastActT = cyc; mLastActB = b; mNoRw = 1; end
    if (eRw) begin mNoRw = 0; if (rd) mDue[(cyc + mLat) % 64] = 1; end
    if (doProg && !mProgPrev) mLat = latOf(mReg[30:28]);
    mProgPrev = doProg;
    if (doLoad) begin mReg = nextWord; if (badWord(nextWord)) mErr = 1; end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic loadWord(input logic [31:0] w);
    doLoad = 1; nextWord = w; step(0, 0, 0, 0, 0, 0, ""); doLoad = 0;
  endtask

  task automatic pulseProg();
    doProg = 1; step(0, 0, 0, 0, 0, 0, ""); doProg = 0; step(0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    finished = 1;
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin mLastAct[i] = -1000; mLastPre[i] = -1000; end
    for (int i = 0; i < 64; i++) mDue[i] = 0;

    // R1: outputs held quiet during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    cmp(gntRef | gntAct | gntPre | gntRw, 1'b0, "grants in reset", "R1");
    cmp(rdValid, 1'b0, "rdValid in reset", "R1");
    cmp(cfgErr, 1'b0, "cfgErr in reset", "R1");
    rstN = 1'b1;

    // R1/R3: reset spacings, PRE after ACT waits 8 clocks
    idle(2);
    step(0, 1, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0, 0, "R3");
    // R4: ACT after PRE waits 3 clocks
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, 0, "R4");
    // R8: back-to-back reads after tRCD, strobes overlap new grants
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, 1, 0, "R8");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, "R8");
    idle(10);
    // R6: second bank ACT blocked until a READ/WRITE follows the first
    step(0, 1, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 0, 0, 1, "R6");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, 1, "R6");
    // R7: everything at once, then REFRESH spacing R2
    for (int i = 0; i < 30; i++) step(1, 1, 1, 1, 1, i % 4, "R7");
    idle(20);
    // R9: latency loaded but not applied until progEn rises
    loadWord(32'h5A73_3225);
    idle(20);
    step(0, 0, 0, 1, 1, 2, "R9");
    idle(10);
    pulseProg();
    step(0, 0, 0, 1, 1, 2, "R9");
    step(0, 0, 0, 1, 1, 2, "R9");
    idle(10);
    // R10: reserved REFRESH code -> 16 clocks, sticky flag
    loadWord(32'h5073_3225);
    for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 0, 0, "R10");
    loadWord(32'h2A70_3225);
    idle(20);
    step(0, 0, 1, 0, 0, 3, "R10");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, 3, "R10");
    idle(20);

    // random traffic under several timing words
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin
        loadWord((k == 3) ? $urandom : ($urandom | 32'h2111_1100));
        pulseProg();
        idle(20);
      end
      for (int i = 0; i < 1500; i++)
        step($urandom % 9 == 0, $urandom % 3 == 0, $urandom % 4 == 0,
             $urandom % 2 == 0, $urandom % 2 == 1, int'($urandom % 4), "");
      idle(20);
    end
    finishRun();
  end
endmodule